// File: doc/BRIEF.md
# Spaced-Command SPI Register Master

This block is an SPI master for single-register reads and writes to a motion sensor. SPI mode 3 is used: SCLK idles high, MOSI changes on the falling edge and both sides sample on the rising edge. A host hands over one command at a time through a valid/ready handshake. A command carries a direction bit, a 7-bit register address and, for writes, one data byte. The block frames the command on the serial pins. For reads it returns the received byte together with a one-cycle completion strobe. The strobe also marks the end of a write.

The sensor needs spacing between serial events, and the block enforces it. It controls the chip-select lead and lag around the clock burst. It inserts an address-to-data pause on reads, and that pause is longer for the two motion registers. It holds chip-select high between commands. The minimum high time depends on whether the finished command was a read or a write, and it never drops below the time needed to leave burst mode. All delays and the SCLK half period are parameters counted in system clock cycles. Gaps are counted from the chip-select rising edge, which keeps them on the safe side of spacing rules that are measured from the end of the last byte.

Top module: `spi_timed_master`

## Requirements
- R1: After reset, spi_ncs and spi_sclk are 1, cmd_ready is 1, rd_done is 0 and rd_data is 0.
- R2: Every command gives exactly 16 SCLK rising edges. The first byte, MSB first, is {direction, address[6:0]}, where direction is 1 for a write and 0 for a read. For writes the second byte is the write data, MSB first. MOSI never changes while SCLK is high.
- R3: The first SCLK rising edge follows the spi_ncs falling edge by CS_LEAD + HALF_SCLK cycles. Consecutive SCLK rising edges are 2*HALF_SCLK cycles apart inside a byte.
- R4: spi_ncs rises exactly CS_LAG cycles after the 16th SCLK rising edge.
- R5: On a read, MISO is sampled on the eight rising edges of the second byte, MSB first. The byte appears on rd_data in the cycle rd_done is high.
- R6: On a read of any address other than 0x02 and 0x50, the first data-byte SCLK falling edge comes RD_WAIT cycles after the 8th rising edge. On a write, the data byte follows after HALF_SCLK cycles.
- R7: On a read of address 0x02 or 0x50, that pause is RD_WAIT_MOTION cycles.
- R8: After a write, cmd_ready stays low and spi_ncs stays high for max(WR_GAP, CS_HIGH) cycles before the next command can start.
- R9: After a read, spi_ncs stays high for max(RD_GAP, CS_HIGH) cycles before the next command. spi_ncs is never high for fewer than CS_HIGH cycles between commands.
- R10: rd_done is a one-cycle pulse in the cycle spi_ncs rises, for reads and writes alike. A write leaves rd_data unchanged.
- R11: SCLK is high whenever spi_ncs is high, and cmd_ready is never high while spi_ncs is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host presents a command |
| cmd_ready | output | 1 | Block accepts the command this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 8 | Write data |
| rd_data | output | 8 | Last byte read |
| rd_done | output | 1 | One-cycle end-of-command strobe |
| spi_ncs | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |

## Verification
A write is the first pattern, and it shows the direction bit and the immediate data byte apart from the read framing. Reads of an ordinary address and of both motion addresses then show that the address-dependent pause picks the right length, and they check the returned bytes. Back-to-back pairs are issued as soon as the previous command ends: write then read, and read then read. The measured chip-select high time tells the write gap apart from the burst-exit floor that governs after a read. A write after a read shows that the returned byte survives a command with no read data.

// File: rtl/spi_timed_master.sv
module spi_timed_master #(
  parameter int unsigned HALF_SCLK      = 4,
  parameter int unsigned CS_LEAD        = 3,
  parameter int unsigned CS_LAG         = 3,
  parameter int unsigned RD_WAIT        = 40,
  parameter int unsigned RD_WAIT_MOTION = 60,
  parameter int unsigned WR_GAP         = 40,
  parameter int unsigned RD_GAP         = 2,
  parameter int unsigned CS_HIGH        = 8,
  parameter logic [6:0]  MOTION_ADDR_A  = 7'h02,
  parameter logic [6:0]  MOTION_ADDR_B  = 7'h50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic       cmd_write,
  input  logic [6:0] cmd_addr,
  input  logic [7:0] cmd_wdata,
  output logic [7:0] rd_data,
  output logic       rd_done,
  output logic       spi_ncs,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  localparam int unsigned GAP_WR = (WR_GAP > CS_HIGH) ? WR_GAP : CS_HIGH;
  localparam int unsigned GAP_RD = (RD_GAP > CS_HIGH) ? RD_GAP : CS_HIGH;
  localparam int unsigned MAX_A  = (GAP_WR > GAP_RD) ? GAP_WR : GAP_RD;
  localparam int unsigned MAX_B  = (RD_WAIT > RD_WAIT_MOTION) ? RD_WAIT : RD_WAIT_MOTION;
  localparam int unsigned MAX_C  = (HALF_SCLK > CS_LEAD) ? HALF_SCLK : CS_LEAD;
  localparam int unsigned MAX_D  = (MAX_C > CS_LAG) ? MAX_C : CS_LAG;
  localparam int unsigned MAX_E  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAXT   = (MAX_E > MAX_D) ? MAX_E : MAX_D;
  localparam int unsigned CW     = $clog2(MAXT + 1);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_SHIFT, S_WAIT, S_LAG} state_t;

  state_t         st;
  logic [CW-1:0]  cnt;
  logic [CW-1:0]  gap;
  logic [15:0]    tx;
  logic [7:0]     rx;
  logic [3:0]     nbit;
  logic           is_write;
  logic           motion;

  assign cmd_ready = (st == S_IDLE) && (gap == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      gap      <= '0;
      tx       <= '0;
      rx       <= '0;
      nbit     <= '0;
      is_write <= 1'b0;
      motion   <= 1'b0;
      rd_data  <= '0;
      rd_done  <= 1'b0;
      spi_ncs  <= 1'b1;
      spi_sclk <= 1'b1;
      spi_mosi <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (gap != '0) begin
            gap <= gap - 1'b1;
          end else if (cmd_valid) begin
            tx       <= {cmd_write, cmd_addr, cmd_write ? cmd_wdata : 8'h00};
            is_write <= cmd_write;
            motion   <= (cmd_addr == MOTION_ADDR_A) || (cmd_addr == MOTION_ADDR_B);
            spi_ncs  <= 1'b0;
            cnt      <= CW'(CS_LEAD - 1);
            st       <= S_LEAD;
          end
        end
        S_LEAD: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            spi_sclk <= 1'b0;
            spi_mosi <= tx[15];
            tx       <= {tx[14:0], 1'b0};
            nbit     <= '0;
            cnt      <= CW'(HALF_SCLK - 1);
            st       <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (!spi_sclk) begin
            spi_sclk <= 1'b1;
            rx       <= {rx[6:0], spi_miso};
            nbit     <= nbit + 1'b1;
            if (nbit == 4'd7 && !is_write) begin
              cnt <= motion ? CW'(RD_WAIT_MOTION - 1) : CW'(RD_WAIT - 1);
              st  <= S_WAIT;
            end else if (nbit == 4'd15) begin
              cnt <= CW'(CS_LAG - 1);
              st  <= S_LAG;
            end else begin
              cnt <= CW'(HALF_SCLK - 1);
            end
          end else begin
            spi_sclk <= 1'b0;
            spi_mosi <= tx[15];
            tx       <= {tx[14:0], 1'b0};
            cnt      <= CW'(HALF_SCLK - 1);
          end
        end
        S_WAIT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            spi_sclk <= 1'b0;
            spi_mosi <= tx[15];
            tx       <= {tx[14:0], 1'b0};
            cnt      <= CW'(HALF_SCLK - 1);
            st       <= S_SHIFT;
          end
        end
        S_LAG: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            spi_ncs <= 1'b1;
            rd_done <= 1'b1;
            if (!is_write) rd_data <= rx;
            gap     <= is_write ? CW'(GAP_WR - 1) : CW'(GAP_RD - 1);
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_cnt <= CW'(CS_HIGH);
    else if (!spi_ncs)          hi_cnt <= '0;
    else if (hi_cnt != CW'(MAXT)) hi_cnt <= hi_cnt + 1'b1;
  end

  p_sclk_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_ncs |-> spi_sclk);

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> spi_ncs);

  p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  p_done_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $rose(spi_ncs));

  p_burst_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_ncs) |-> (hi_cnt >= CW'(CS_HIGH)));

endmodule

// File: tb/spi_timed_master_test.sv
module spi_timed_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4, LEAD = 3, LAG = 3, RDW = 40, RDWM = 60;
  localparam int WRG = 40, RDG = 2, CSH = 8;
  localparam int GAPW = (WRG > CSH) ? WRG : CSH;
  localparam int GAPR = (RDG > CSH) ? RDG : CSH;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_write = 0, spi_miso = 0;
  logic [6:0] cmd_addr = 0;
  logic [7:0] cmd_wdata = 0;
  logic cmd_ready, rd_done, spi_ncs, spi_sclk, spi_mosi;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_timed_master #(
    .HALF_SCLK(HALF), .CS_LEAD(LEAD), .CS_LAG(LAG), .RD_WAIT(RDW),
    .RD_WAIT_MOTION(RDWM), .WR_GAP(WRG), .RD_GAP(RDG), .CS_HIGH(CSH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rd_data(rd_data), .rd_done(rd_done), .spi_ncs(spi_ncs),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int cyc = 0, nr = 0, nf = 0;
  int t_nf = 0, t_nr = 0, t_r1 = 0, t_r2 = 0, t_r8 = 0, t_r16 = 0, t_f9 = 0, hi_len = 0;
  logic [15:0] frame = 0;
  logic [7:0]  resp = 0;
  logic prev_ncs = 1, prev_sclk = 1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (prev_ncs && !spi_ncs) begin
      t_nf <= cyc; nr <= 0; nf <= 0; frame <= 0; hi_len <= cyc - t_nr;
    end
    if (!prev_ncs && spi_ncs) t_nr <= cyc;
    if (!spi_ncs && prev_sclk && !spi_sclk) begin
      nf <= nf + 1;
      if (nf + 1 == 9) t_f9 <= cyc;
      if (nf + 1 >= 9) spi_miso <= resp[16 - (nf + 1)];
    end
    if (!spi_ncs && !prev_sclk && spi_sclk) begin
      nr <= nr + 1;
      frame <= {frame[14:0], spi_mosi};
      if (nr + 1 == 1)  t_r1  <= cyc;
      if (nr + 1 == 2)  t_r2  <= cyc;
      if (nr + 1 == 8)  t_r8  <= cyc;
      if (nr + 1 == 16) t_r16 <= cyc;
    end
    prev_ncs  <= spi_ncs;
    prev_sclk <= spi_sclk;
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_cmd(input logic w, input logic [6:0] a, input logic [7:0] d,
                        input logic [7:0] r);
    resp = r; cmd_write = w; cmd_addr = a; cmd_wdata = d; cmd_valid = 1;
    while (!cmd_ready) tick();
    tick();
    cmd_valid = 0;
    while (!rd_done) tick();
    check("R10 ncs high with done", int'(spi_ncs), 1);
    tick();
    check("R10 done one cycle", int'(rd_done), 0);
  endtask

  task automatic test_reset();
    check("R1 ncs", int'(spi_ncs), 1);
    check("R1 sclk", int'(spi_sclk), 1);
    check("R1 ready", int'(cmd_ready), 1);
    check("R1 done", int'(rd_done), 0);
    check("R1 rd_data", int'(rd_data), 0);
  endtask

  task automatic test_write();
    do_cmd(1'b1, 7'h2A, 8'hC3, 8'h00);
    check("R2 write frame", int'(frame), int'({1'b1, 7'h2A, 8'hC3}));
    check("R2 rise count", nr, 16);
    check("R3 lead", t_r1 - t_nf, LEAD + HALF);
    check("R3 period", t_r2 - t_r1, 2 * HALF);
    check("R6 write no pause", t_f9 - t_r8, HALF);
    check("R4 lag", t_nr - t_r16, LAG);
  endtask

  task automatic test_read_plain();
    do_cmd(1'b0, 7'h11, 8'hFF, 8'hA5);
    check("R2 read addr byte", int'(frame[15:8]), int'({1'b0, 7'h11}));
    check("R5 read data", int'(rd_data), 8'hA5);
    check("R6 read pause", t_f9 - t_r8, RDW);
    check("R4 lag read", t_nr - t_r16, LAG);
  endtask

  task automatic test_read_motion();
    do_cmd(1'b0, 7'h02, 8'h00, 8'h3C);
    check("R7 pause addr 0x02", t_f9 - t_r8, RDWM);
    check("R5 data addr 0x02", int'(rd_data), 8'h3C);
    do_cmd(1'b0, 7'h50, 8'h00, 8'h81);
    check("R7 pause addr 0x50", t_f9 - t_r8, RDWM);
    check("R5 data addr 0x50", int'(rd_data), 8'h81);
  endtask

  task automatic test_gaps();
    do_cmd(1'b1, 7'h05, 8'h5A, 8'h00);
    check("R8 ready low after write", int'(cmd_ready), 0);
    do_cmd(1'b0, 7'h06, 8'h00, 8'h96);
    check("R8 gap after write", hi_len, GAPW);
    check("R5 data after write", int'(rd_data), 8'h96);
    do_cmd(1'b0, 7'h07, 8'h00, 8'h0F);
    check("R9 gap after read", hi_len, GAPR);
    do_cmd(1'b1, 7'h08, 8'hE7, 8'hFF);
    check("R9 gap read then write", hi_len, GAPR);
    check("R10 rd_data kept by write", int'(rd_data), 8'h0F);
    check("R2 frame second write", int'(frame), int'({1'b1, 7'h08, 8'hE7}));
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    test_reset();
    test_write();
    test_read_plain();
    test_read_motion();
    test_gaps();
    repeat (5) tick();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule